// File: doc/BRIEF.md
# Four-Channel Interrupt Aggregator

This block gathers four active-low interrupt request lines, one for each downstream bus channel. It merges them into a single combined interrupt for an open-drain pin. Each request line is first brought into the local clock domain by its own two-stage synchronizer. The combined pin is modelled as an output enable. When the enable is high the pad pulls low, and the pad's data value is always 0. The combined interrupt is level-following. It drops as soon as every requesting source lets go, and the host never has to clear it.

The block also supplies the 8-bit value that a host register interface returns on a control-register read. The upper nibble is a snapshot of which channels are requesting service, taken on the read strobe. The lower nibble is a channel-select value the host wrote earlier. The snapshot follows the lines as they are when the read happens and does not accumulate. Detection does not depend on which channel is selected. Only control and status pins are present, and there is no streaming interface, so no valid/ready handshake applies.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low, and until new stimulus arrives after reset, `irq_oe_o` is 0 and `rd_data_o` is 8'h00.
- R2: `irq_oe_o` is 1 exactly when at least one synchronized request is low. A change on `irq_n_i` that is stable before clock edge k appears on `irq_oe_o` after edge k+1 (two-edge latency).
- R3: A request on a channel raises `irq_oe_o` and its status bit whatever value the channel-select nibble holds.
- R4: Status bit 4+i of `rd_data_o` reports channel i (bit 4 = channel 0 through bit 7 = channel 3). On the edge where `rd_strobe_i` is 1, each bit loads 1 if that channel's synchronized request is low, and 0 otherwise.
- R5: The status nibble changes only on edges where `rd_strobe_i` is 1. Between strobes it holds its value even if the request lines change.
- R6: Any combination of the four status bits can be set at once. For example, with channels 1 and 2 requesting and channels 0 and 3 idle, the nibble reads 4'b0110.
- R7: Two edges after every request line returns high, `irq_oe_o` falls to 0 with no host action.
- R8: A request line held high never drives `irq_oe_o` or sets its status bit.
- R9: Bits 3:0 of `rd_data_o` hold the channel-select value loaded from `wr_data_i[3:0]` on an edge where `wr_en_i` is 1. `wr_data_i[7:4]` is ignored and a write never alters the status nibble.
- R10: `irq_out_o`, the pad data value, is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 4 | Active-low interrupt requests, bit i = channel i |
| rd_strobe_i | input | 1 | Control-register read; captures status |
| wr_en_i | input | 1 | Control-register write enable |
| wr_data_i | input | 8 | Control-register write data |
| rd_data_o | output | 8 | Control-register read value {status, select} |
| irq_oe_o | output | 1 | Combined interrupt output enable (1 = pull pin low) |
| irq_out_o | output | 1 | Combined interrupt pad data, fixed 0 |

## Verification
Single-channel requests are applied while a different channel is selected. This separates real per-channel detection from gating by the select value, and confirms which status bit each channel lands in. A two-channel pattern and an all-released pattern show that bits combine without masking, and that both the output and the snapshot fall without any clear. Long random runs mix request toggles with strobes and writes on the same edge. They separate correct two-edge latency and capture-only-on-read from designs that read the lines live or let a write disturb the status.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned REG_W   = NUM_CH + SEL_W;
  localparam int unsigned STAT_LO = SEL_W;

  typedef logic [NUM_CH-1:0] ch_vec_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [REG_W-1:0]  reg_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync
  import irq_agg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t async_n,
  output ch_vec_t sync_n
);
  // one flop chain per channel, reset to the inactive (high) level
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_n[c]};
    end
    assign sync_n[c] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_agg_pkg::*;
(
  input  ch_vec_t sync_n,
  output logic    pad_oe,
  output logic    pad_out
);
  ch_vec_t active;
  always_comb begin
    active = ~sync_n;
    pad_oe = |active;
  end
  // open-drain pad: only the enable moves, the data is always low
  assign pad_out = 1'b0;
endmodule

// File: rtl/irq_status_cap.sv
module irq_status_cap
  import irq_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t sync_n,
  input  logic    rd_strobe,
  input  logic    wr_en,
  input  reg_t    wr_data,
  output reg_t    rd_value
);
  ch_vec_t stat_q;
  sel_t    sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_q <= '0;
    else if (rd_strobe) stat_q <= ~sync_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data[SEL_W-1:0];
  end

  assign rd_value = {stat_q, sel_q};
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_n_i,
  input  logic       rd_strobe_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_oe_o,
  output logic       irq_out_o
);
  ch_vec_t sync_n;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (irq_n_i),
    .sync_n  (sync_n)
  );

  irq_combine u_comb (
    .sync_n  (sync_n),
    .pad_oe  (irq_oe_o),
    .pad_out (irq_out_o)
  );

  irq_status_cap u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .rd_strobe (rd_strobe_i),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .rd_value  (rd_data_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_n_i,
  input logic       rd_strobe_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       irq_oe_o
);
  // cycles since reset, saturating; gates $past lookbacks
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  oe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (irq_oe_o == (|(~$past(irq_n_i, 2)))));

  // R4
  status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && age_q >= 2'd2) |=> (rd_data_o[7:4] == ~$past(irq_n_i, 3)));

  // R5
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_i && age_q >= 2'd1) |=> $stable(rd_data_o[7:4]));

  // R9
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o[3:0] == $past(wr_data_i[3:0])));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && age_q >= 2'd1) |=> $stable(rd_data_o[3:0]));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_n_i     (irq_n_i),
  .rd_strobe_i (rd_strobe_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .irq_oe_o    (irq_oe_o)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_n = 4'hF;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic       oe;
  logic       pad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  irq_aggregator dut_i (
    .clk (clk), .rst_n (rst_n), .irq_n_i (irq_n), .rd_strobe_i (rd),
    .wr_en_i (wr), .wr_data_i (wdata), .rd_data_o (rd_data),
    .irq_oe_o (oe), .irq_out_o (pad)
  );

  // behavioural reference: delay line of sampled inputs plus two registers
  int hist[$];
  int m_stat = 0;
  int m_sel = 0;
  bit m_oe = 0;
  bit cmp_en = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{15, 15};
      m_stat = 0; m_sel = 0; m_oe = 0;
    end else begin
      if (rd) m_stat = (~hist[0]) & 15;
      if (wr) m_sel = wdata & 15;
      void'(hist.pop_front());
      hist.push_back(int'(irq_n));
      m_oe = (hist[0] != 15);
    end
    #1;
    if (cmp_en) begin
      chk("R2 oe", int'(oe), int'(m_oe));
      chk("R4 status", int'(rd_data[7:4]), m_stat);
      chk("R9 select", int'(rd_data[3:0]), m_sel);
      chk("R10 pad", int'(pad), 0);
    end
  end

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; nclk(1); rd = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nclk(3);
    chk("R1 oe in reset", int'(oe), 0);
    chk("R1 rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    nclk(2);
    chk("R1 oe after reset", int'(oe), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    cmp_en = 1'b1;

    // R9: upper write bits ignored
    wr = 1'b1; wdata = 8'hFA; nclk(1); wr = 1'b0;
    chk("R9 select load", int'(rd_data), 8'h0A);

    // R3 / R2: channel 1 requests while select holds another value
    irq_n = 4'b1101;
    nclk(1);
    chk("R2 oe not yet after one edge", int'(oe), 0);
    nclk(1);
    chk("R3 oe with unselected channel", int'(oe), 1);
    chk("R5 status not live", int'(rd_data[7:4]), 0);
    do_read();
    chk("R4 channel 1 -> bit 5", int'(rd_data), 8'h2A);

    // R6: channels 1 and 2 together
    irq_n = 4'b1001; nclk(2);
    do_read();
    chk("R6 two channels", int'(rd_data[7:4]), 4'b0110);

    // R4 mapping per channel
    for (int c = 0; c < 4; c++) begin
      irq_n = ~(4'b0001 << c); nclk(2);
      do_read();
      chk("R4 bit position", int'(rd_data[7:4]), 1 << c);
    end

    // R7 / R5: release, no clear
    irq_n = 4'hF; nclk(1);
    chk("R7 oe still set one edge after release", int'(oe), 1);
    nclk(1);
    chk("R7 oe released", int'(oe), 0);
    chk("R5 status holds without read", int'(rd_data[7:4]), 4'b1000);
    // R9: write on same edge as read does not disturb status
    wr = 1'b1; wdata = 8'h53; rd = 1'b1; nclk(1); wr = 1'b0; rd = 1'b0;
    chk("R9 write beside read", int'(rd_data), 8'h03);

    // R8: lines held high for many edges
    for (int k = 0; k < 8; k++) begin
      nclk(1);
      chk("R8 idle lines", int'(oe), 0);
    end
    do_read();
    chk("R8 idle status", int'(rd_data[7:4]), 0);

    // random mix compared every clock by the model
    for (int k = 0; k < 2000; k++) begin
      irq_n = ($urandom % 3 == 0) ? 4'(($urandom)) : irq_n;
      rd = ($urandom % 4 == 0);
      wr = ($urandom % 6 == 0);
      wdata = 8'($urandom);
      nclk(1);
    end
    rd = 1'b0; wr = 1'b0;
    nclk(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule